// File: doc/BRIEF.md
# DRAM Command Spacing Tracker

This block sits beside the command scheduler of one DRAM channel that serves several ranks, each with several banks. It watches every command the scheduler issues (activate, read, write, precharge-all and refresh, each tagged with a rank and a bank). It keeps a set of saturating down-counters that measure how long ago the constraining commands were issued. From those counters it produces two sets of "may issue" flags: one read flag per rank-bank and one refresh flag per rank. The scheduler uses these flags to decide what it can legally send in the current clock.

All minimum gaps are programmable, in DRAM clocks, through two configuration words behind a small write/read-back port. Read turnarounds keep separate limits for the same rank and for a different rank. Activate-to-read is tracked for each rank-bank pair, and refresh spacing is tracked for each rank. Every counter is a two-state machine. In `GC_IDLE` the count is zero. In `GC_COUNT` the count is non-zero. A counter takes the transition `GC_IDLE -> GC_COUNT` when it loads a limit of 2 or more. It takes `GC_COUNT -> GC_IDLE` when it decrements from 1. It stays in `GC_COUNT` while it decrements from above 1 or is reloaded. If the scheduler issues a read or refresh while its flag is low, a sticky violation flag is raised, and the counters are still updated as for any command.

Top module: `dram_cmd_spacing`

## Requirements
- R1: After reset, both configuration words read back as zero, every `rd_ok` and `ref_ok` bit is 1, and `viol` is 0.
- R2: The configuration word at `cfg_addr`=0 holds these fields: activate-to-read in [3:0], same-rank write-to-read in [8:4] (5 bits), different-rank write-to-read in [12:9], same-rank read-to-read in [16:13] and different-rank read-to-read in [20:17]. The word at `cfg_addr`=1 holds precharge-all-to-refresh in [3:0] and refresh-to-refresh in [12:4] (9 bits). Bits above these fields always read 0, and writes to them are ignored. `cfg_rdata` shows the word selected by `cfg_addr` in the same cycle.
- R3: Let a limit N be loaded by a command issued in cycle t. The flags it gates are then low from cycle t+1 to cycle t+N-1, and they are high again from cycle t+max(N,1). A limit of 0 or 1 therefore never blocks anything.
- R4: An activate (`cmd_type`=0) to rank r, bank b lowers only `rd_ok[r*NUM_BANKS+b]` for the activate-to-read limit.
- R5: A write (`cmd_type`=2) to rank r holds back reads to every bank of rank r for the same-rank write-to-read limit. It holds back reads to every bank of every other rank for the different-rank write-to-read limit.
- R6: A read (`cmd_type`=1) to rank r holds back reads to rank r for the same-rank read-to-read limit. It holds back reads to every other rank for the different-rank read-to-read limit.
- R7: A precharge-all (`cmd_type`=3) to rank r lowers `ref_ok[r]` for the precharge-all-to-refresh limit. A refresh (`cmd_type`=4) to rank r lowers `ref_ok[r]` for the refresh-to-refresh limit. Neither command touches the refresh flag of any other rank.
- R8: When a counter that is already running is loaded again, it keeps whichever wait ends later. A new command never shortens a spacing that is still in force.
- R9: A read issued while its `rd_ok` bit is 0, or a refresh issued while its `ref_ok` bit is 0, sets `viol` from the next cycle. `viol` then stays set until reset. The illegal command still loads its counters.
- R10: A command whose rank is at or beyond `NUM_RANKS`, or whose bank is at or beyond `NUM_BANKS`, is ignored. It loads no counter and cannot set `viol`.
- R11: `cmd_type` codes 5 to 7 are ignored. Activate, write and precharge-all can never set `viol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DRAM clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_type | input | 3 | 0 activate, 1 read, 2 write, 3 precharge-all, 4 refresh |
| cmd_rank | input | RANK_W | Target rank |
| cmd_bank | input | BANK_W | Target bank |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | Configuration word select |
| cfg_wdata | input | 24 | Configuration write data |
| cfg_rdata | output | 24 | Read-back of the selected word |
| rd_ok | output | NUM_RANKS*NUM_BANKS | Read may issue, one bit per rank-bank |
| ref_ok | output | NUM_RANKS | Refresh may issue, one bit per rank |
| viol | output | 1 | Sticky spacing violation |

## Verification
The bench builds the block with `NUM_RANKS`=3 and `NUM_BANKS`=2. With three ranks, one command loads the different-rank counters of two ranks, and one rank can be shown to stay untouched. The unused rank code 3 gives an out-of-range command to test that such commands are ignored. The refresh-to-refresh limit is set to 300, which exercises the upper bits of the 9-bit counter. A reload test issues a short activate while a long one is still counting, and checks that the longer wait survives.

// File: rtl/cst_pkg.sv
package cst_pkg;
    localparam int CFG_W     = 24;
    localparam int ACT_RD_W  = 4;
    localparam int WTR_S_W   = 5;
    localparam int WTR_D_W   = 4;
    localparam int RTR_S_W   = 4;
    localparam int RTR_D_W   = 4;
    localparam int PA_REF_W  = 4;
    localparam int REF_REF_W = 9;

    typedef enum logic [2:0] {
        CMD_ACT    = 3'd0,
        CMD_READ   = 3'd1,
        CMD_WRITE  = 3'd2,
        CMD_PREALL = 3'd3,
        CMD_REF    = 3'd4
    } cmd_e;

    typedef enum logic {
        GC_IDLE  = 1'b0,
        GC_COUNT = 1'b1
    } gc_state_e;

    typedef struct packed {
        logic [RTR_D_W-1:0]  rtr_diff;
        logic [RTR_S_W-1:0]  rtr_same;
        logic [WTR_D_W-1:0]  wtr_diff;
        logic [WTR_S_W-1:0]  wtr_same;
        logic [ACT_RD_W-1:0] act_rd;
    } rd_timing_t;

    typedef struct packed {
        logic [REF_REF_W-1:0] ref_ref;
        logic [PA_REF_W-1:0]  pa_ref;
    } ref_timing_t;

    localparam int RD_BITS  = $bits(rd_timing_t);
    localparam int REF_BITS = $bits(ref_timing_t);
endpackage

// File: rtl/cst_cfg_regs.sv
module cst_cfg_regs
    import cst_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic             addr,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] rdata,
    output rd_timing_t       rd_cfg,
    output ref_timing_t      ref_cfg
);
    rd_timing_t  rd_q;
    ref_timing_t ref_q;
    logic        unused_wdata_hi;

    assign unused_wdata_hi = ^wdata[CFG_W-1:RD_BITS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= '0;
            ref_q <= '0;
        end else if (we) begin
            if (addr) ref_q <= wdata[REF_BITS-1:0];
            else      rd_q  <= wdata[RD_BITS-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        if (addr) rdata[REF_BITS-1:0] = ref_q;
        else      rdata[RD_BITS-1:0]  = rd_q;
    end

    assign rd_cfg  = rd_q;
    assign ref_cfg = ref_q;
endmodule

// File: rtl/cst_gap_counter.sv
module cst_gap_counter
    import cst_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] limit,
    output logic             clear
);
    gc_state_e        state_q, state_d;
    logic [WIDTH-1:0] cnt_q, cnt_d, dec, ld_val;

    always_comb begin
        dec     = (cnt_q == '0)  ? '0 : cnt_q - 1'b1;
        ld_val  = (limit == '0)  ? '0 : limit - 1'b1;
        cnt_d   = (load && (ld_val > dec)) ? ld_val : dec;
        state_d = state_q;
        unique case (state_q)
            GC_IDLE:  if (cnt_d != '0) state_d = GC_COUNT;
            GC_COUNT: if (cnt_d == '0) state_d = GC_IDLE;
            default:  state_d = GC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= GC_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign clear = (state_q == GC_IDLE);

    // R3
    decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R8
    reload_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q > 1) |=> !clear);
endmodule

// File: rtl/dram_cmd_spacing.sv
module dram_cmd_spacing
    import cst_pkg::*;
#(
    parameter int NUM_RANKS = 2,
    parameter int NUM_BANKS = 8,
    localparam int RANK_W = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
    localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cmd_valid,
    input  logic [2:0]                     cmd_type,
    input  logic [RANK_W-1:0]              cmd_rank,
    input  logic [BANK_W-1:0]              cmd_bank,
    input  logic                           cfg_we,
    input  logic                           cfg_addr,
    input  logic [CFG_W-1:0]               cfg_wdata,
    output logic [CFG_W-1:0]               cfg_rdata,
    output logic [NUM_RANKS*NUM_BANKS-1:0] rd_ok,
    output logic [NUM_RANKS-1:0]           ref_ok,
    output logic                           viol
);
    localparam int NUM_RB = NUM_RANKS * NUM_BANKS;
    localparam int IDX_W  = (NUM_RB > 1) ? $clog2(NUM_RB) : 1;

    rd_timing_t  rd_cfg;
    ref_timing_t ref_cfg;
    logic        rank_in, bank_in, hit;
    logic        act_hit, rd_hit, wr_hit, pa_hit, ref_hit;
    logic [IDX_W-1:0] rd_idx;
    logic        viol_q;

    cst_cfg_regs u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .rdata   (cfg_rdata),
        .rd_cfg  (rd_cfg),
        .ref_cfg (ref_cfg)
    );

    generate
        if (NUM_RANKS == (1 << RANK_W)) begin : g_rank_full
            assign rank_in = 1'b1;
        end else begin : g_rank_part
            assign rank_in = (int'(cmd_rank) < NUM_RANKS);
        end
        if (NUM_BANKS == (1 << BANK_W)) begin : g_bank_full
            assign bank_in = 1'b1;
        end else begin : g_bank_part
            assign bank_in = (int'(cmd_bank) < NUM_BANKS);
        end
    endgenerate

    assign hit     = cmd_valid && rank_in && bank_in;
    assign act_hit = hit && (cmd_type == CMD_ACT);
    assign rd_hit  = hit && (cmd_type == CMD_READ);
    assign wr_hit  = hit && (cmd_type == CMD_WRITE);
    assign pa_hit  = hit && (cmd_type == CMD_PREALL);
    assign ref_hit = hit && (cmd_type == CMD_REF);
    assign rd_idx  = IDX_W'(int'(cmd_rank) * NUM_BANKS + int'(cmd_bank));

    genvar r, b;
    generate
        for (r = 0; r < NUM_RANKS; r++) begin : g_rank
            logic same, wrs_c, wrd_c, rds_c, rdd_c, pa_c, rf_c, rank_clear;
            assign same = (int'(cmd_rank) == r);

            cst_gap_counter #(.WIDTH(WTR_S_W)) u_wr_same (
                .clk(clk), .rst_n(rst_n), .load(wr_hit && same),
                .limit(rd_cfg.wtr_same), .clear(wrs_c));
            cst_gap_counter #(.WIDTH(WTR_D_W)) u_wr_diff (
                .clk(clk), .rst_n(rst_n), .load(wr_hit && !same),
                .limit(rd_cfg.wtr_diff), .clear(wrd_c));
            cst_gap_counter #(.WIDTH(RTR_S_W)) u_rd_same (
                .clk(clk), .rst_n(rst_n), .load(rd_hit && same),
                .limit(rd_cfg.rtr_same), .clear(rds_c));
            cst_gap_counter #(.WIDTH(RTR_D_W)) u_rd_diff (
                .clk(clk), .rst_n(rst_n), .load(rd_hit && !same),
                .limit(rd_cfg.rtr_diff), .clear(rdd_c));
            cst_gap_counter #(.WIDTH(PA_REF_W)) u_pa_ref (
                .clk(clk), .rst_n(rst_n), .load(pa_hit && same),
                .limit(ref_cfg.pa_ref), .clear(pa_c));
            cst_gap_counter #(.WIDTH(REF_REF_W)) u_ref_ref (
                .clk(clk), .rst_n(rst_n), .load(ref_hit && same),
                .limit(ref_cfg.ref_ref), .clear(rf_c));

            assign rank_clear = wrs_c && wrd_c && rds_c && rdd_c;
            assign ref_ok[r]  = pa_c && rf_c;

            for (b = 0; b < NUM_BANKS; b++) begin : g_bank
                logic act_c;
                cst_gap_counter #(.WIDTH(ACT_RD_W)) u_act (
                    .clk(clk), .rst_n(rst_n),
                    .load(act_hit && same && (int'(cmd_bank) == b)),
                    .limit(rd_cfg.act_rd), .clear(act_c));
                assign rd_ok[r*NUM_BANKS + b] = act_c && rank_clear;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) viol_q <= 1'b0;
        else if ((rd_hit && !rd_ok[rd_idx]) || (ref_hit && !ref_ok[cmd_rank]))
            viol_q <= 1'b1;
    end

    assign viol = viol_q;

    // R9
    viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol |=> viol);

    // R9
    viol_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && !rd_ok[rd_idx]) |=> viol);

    // R4
    act_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_hit && rd_cfg.act_rd > 1) |=> !rd_ok[$past(rd_idx)]);

    // R7
    ref_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_hit && ref_cfg.ref_ref > 1) |=> !ref_ok[$past(cmd_rank)]);
endmodule

// File: tb/tb_dram_cmd_spacing.sv
module tb_dram_cmd_spacing;
    localparam int NR = 3;
    localparam int NB = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_type = 3'd0;
    logic [1:0]    cmd_rank = 2'd0;
    logic [0:0]    cmd_bank = 1'b0;
    logic          cfg_we = 1'b0;
    logic          cfg_addr = 1'b0;
    logic [23:0]   cfg_wdata = '0;
    logic [23:0]   cfg_rdata;
    logic [NR*NB-1:0] rd_ok;
    logic [NR-1:0] ref_ok;
    logic          viol;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    dram_cmd_spacing #(.NUM_RANKS(NR), .NUM_BANKS(NB)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
        .cmd_rank(cmd_rank), .cmd_bank(cmd_bank), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .rd_ok(rd_ok), .ref_ok(ref_ok), .viol(viol));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic issue(input int t, input int r, input int b);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_type  = 3'(t);
        cmd_rank  = 2'(r);
        cmd_bank  = 1'(b);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic cfg_write(input bit a, input logic [23:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input bit a, output int v);
        cfg_addr = a;
        #1;
        v = int'(cfg_rdata);
    endtask

    function automatic logic [23:0] rd_word(int ar, int ws, int wd, int rs, int rd);
        return 24'(ar | (ws << 4) | (wd << 9) | (rs << 13) | (rd << 17));
    endfunction

    // cycles after a command until the flag is high again (1 = next cycle)
    task automatic gap_rd(input int r, input int b, output int k);
        k = 1;
        while (!rd_ok[r*NB+b] && k < 1000) begin @(negedge clk); k++; end
    endtask

    task automatic gap_ref(input int r, output int k);
        k = 1;
        while (!ref_ok[r] && k < 1000) begin @(negedge clk); k++; end
    endtask

    task automatic t_reset;
        int v;
        cfg_read(1'b0, v); chk("R1 rd word", v, 0);
        cfg_read(1'b1, v); chk("R1 ref word", v, 0);
        chk("R1 rd_ok", int'(rd_ok), (1 << (NR*NB)) - 1);
        chk("R1 ref_ok", int'(ref_ok), (1 << NR) - 1);
        chk("R1 viol", int'(viol), 0);
    endtask

    task automatic t_cfg;
        int v;
        cfg_write(1'b0, 24'hFFFFFF); cfg_read(1'b0, v);
        chk("R2 rd word reserved", v, 24'h1FFFFF);
        cfg_write(1'b1, 24'hFFFFFF); cfg_read(1'b1, v);
        chk("R2 ref word reserved", v, 24'h001FFF);
        cfg_write(1'b0, rd_word(5, 12, 3, 4, 2));
        cfg_write(1'b1, 24'(6 | (300 << 4)));
        cfg_read(1'b0, v); chk("R2 rd fields", v, int'(rd_word(5, 12, 3, 4, 2)));
        cfg_read(1'b1, v); chk("R2 ref fields", v, 6 | (300 << 4));
    endtask

    task automatic t_act;
        int k;
        idle(20);
        issue(0, 1, 0);
        chk("R4 other bank same rank", int'(rd_ok[1*NB+1]), 1);
        chk("R4 same bank other rank", int'(rd_ok[0]), 1);
        gap_rd(1, 0, k); chk("R4 R3 act-to-read gap", k, 5);
    endtask

    task automatic t_write;
        int k;
        idle(20);
        issue(2, 0, 0);
        chk("R5 rank 1 blocked", int'(rd_ok[1*NB]), 0);
        gap_rd(0, 1, k); chk("R5 same-rank wtr gap", k, 12);
        idle(20);
        issue(2, 0, 0);
        gap_rd(2, 1, k); chk("R5 diff-rank wtr gap", k, 3);
    endtask

    task automatic t_read;
        int k;
        idle(20);
        issue(1, 1, 1);
        gap_rd(1, 0, k); chk("R6 same-rank read gap", k, 4);
        idle(20);
        issue(1, 1, 1);
        gap_rd(0, 0, k); chk("R6 diff-rank read gap", k, 2);
        chk("R9 legal reads no viol", int'(viol), 0);
    endtask

    task automatic t_refresh;
        int k;
        idle(20);
        issue(3, 2, 0);
        chk("R7 other rank ref_ok", int'(ref_ok[0]), 1);
        gap_ref(2, k); chk("R7 preall-to-ref gap", k, 6);
        issue(4, 2, 0);
        chk("R7 ref other rank", int'(ref_ok[1]), 1);
        gap_ref(2, k); chk("R7 ref-to-ref gap", k, 300);
        chk("R9 legal refresh no viol", int'(viol), 0);
    endtask

    task automatic t_reload;
        int k;
        idle(20);
        cfg_write(1'b0, rd_word(10, 12, 3, 4, 2));
        issue(0, 0, 0);
        cfg_write(1'b0, rd_word(2, 12, 3, 4, 2));
        issue(0, 0, 0);
        // first activate, four cycles earlier, still needs 6 more cycles
        gap_rd(0, 0, k); chk("R8 longer wait kept", k, 6);
        cfg_write(1'b0, rd_word(5, 12, 3, 4, 2));
    endtask

    task automatic t_ignore;
        idle(20);
        issue(2, 3, 0);
        chk("R10 out-of-range write", int'(rd_ok), (1 << (NR*NB)) - 1);
        issue(4, 3, 0);
        chk("R10 out-of-range refresh", int'(ref_ok), (1 << NR) - 1);
        issue(5, 0, 0); issue(6, 1, 1); issue(7, 2, 0);
        chk("R11 unused codes rd_ok", int'(rd_ok), (1 << (NR*NB)) - 1);
        chk("R11 unused codes ref_ok", int'(ref_ok), (1 << NR) - 1);
        issue(2, 0, 0); issue(2, 0, 0); issue(0, 1, 1); issue(0, 1, 1);
        issue(3, 2, 0); issue(3, 2, 0);
        chk("R11 no viol from act/write/preall", int'(viol), 0);
    endtask

    task automatic t_viol;
        int v;
        idle(20);
        issue(0, 0, 0);
        issue(1, 0, 0);
        chk("R9 illegal read sets viol", int'(viol), 1);
        chk("R9 counters still loaded", int'(rd_ok[1]), 0);
        idle(20);
        chk("R9 viol sticky", int'(viol), 1);
        @(negedge clk); rst_n = 1'b0;
        idle(2); rst_n = 1'b1;
        @(negedge clk);
        chk("R1 viol after reset", int'(viol), 0);
        cfg_read(1'b0, v); chk("R1 cfg after reset", v, 0);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cfg();
        t_act();
        t_write();
        t_read();
        t_refresh();
        t_reload();
        t_ignore();
        t_viol();
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        finish_run();
    end
endmodule